// File: doc/BRIEF.md
# Word-Wide Arithmetic, Logic and Compare Unit

This block is the execution datapath of a simple load/store processor. It is purely combinational. It takes two operands of `WIDTH` bits and a 4-bit operation selector. From these it produces one result word and a flag that is high when every bit of the result is zero. A single adder, wired as a subtractor, serves both subtraction and the three signed comparisons. Comparison outputs are plain booleans: the value 1 or the value 0 in a full-width word.

Shifts take their distance from the low `log2(WIDTH)` bits of the second operand only. A requested distance equal to the word width therefore wraps to zero and leaves the operand as it was. The shifter can be built in either of two forms, chosen by a parameter:

- a logarithmic stage network, or
- plain language shift operators.

The unit does not pick operands, extend literals or write results back. The pipeline around it does those jobs.

Top module: `alu32_core`

## Requirements
- R1: Code 0 (add) returns A+B modulo 2^WIDTH, with the carry out discarded; for example 0xAAAAAAAA+0xAAAAAAAA gives 0x55555554.
- R2: Code 1 (subtract) returns A-B modulo 2^WIDTH, with the borrow running through every bit; for example 1-1 gives 0 and 0-1 gives 0xFFFFFFFF.
- R3: Code 2 (equal) returns 1 when A equals B and 0 otherwise; bits above bit 0 are always zero.
- R4: Code 3 (signed less-than) returns 1 exactly when A < B as two's complement numbers, even when A-B overflows.
- R5: Code 4 (signed less-or-equal) returns 1 exactly when A <= B signed; 0x80000000<=0x7FFFFFFF gives 1 and 0x7FFFFFFF<=0x80000000 gives 0.
- R6: Codes 5, 6, 7 and 8 return the bitwise AND, OR, XOR and XNOR of A and B; XNOR of 0x00000F0F and 0x00007F00 gives 0xFFFF8FF0.
- R7: Code 9 shifts A left by B[4:0] and fills with zeros; B=32 returns A unchanged.
- R8: Code 10 shifts A right logically by B[4:0]; 0x80000000 by 17 gives 0x00004000.
- R9: Code 11 shifts A right arithmetically by B[4:0] and copies bit 31 into the vacated bits; 0x80000000 by 17 gives 0xFFFFC000.
- R10: The zero flag is 1 exactly when all result bits are 0.
- R11: Codes 12 to 15 are undefined and return a result of 0, with the zero flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 4 | Operation selector (codes as listed in the requirements) |
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand; its low log2(WIDTH) bits give the shift distance |
| result_o | output | WIDTH | Operation result |
| zero_o | output | 1 | High when result_o is all zeros |

## Verification
The bench builds two copies at WIDTH=32:

- one with the staged shifter (SHIFT_STAGED=1);
- one with the operator shifter (SHIFT_STAGED=0).

Both copies are compared against the same behavioural model on every clock, so both shifter variants are exercised by the same stimulus, including the stage carrying the 16-bit hop and the wrap of a distance of 32. The 32-bit width puts the stated corner values within reach: the most negative and most positive words, the alternating-bit patterns and the 17-bit signed shift.

// File: rtl/alu32_pkg.sv
package alu32_pkg;
   typedef enum logic [3:0] {
      OP_ADD  = 4'd0,
      OP_SUB  = 4'd1,
      OP_CEQ  = 4'd2,
      OP_CLT  = 4'd3,
      OP_CLE  = 4'd4,
      OP_AND  = 4'd5,
      OP_OR   = 4'd6,
      OP_XOR  = 4'd7,
      OP_XNOR = 4'd8,
      OP_SHL  = 4'd9,
      OP_SHR  = 4'd10,
      OP_SRA  = 4'd11
   } alu_op_e;

   typedef enum logic [1:0] {
      BW_AND  = 2'd0,
      BW_OR   = 2'd1,
      BW_XOR  = 2'd2,
      BW_XNOR = 2'd3
   } bw_sel_e;
endpackage

// File: rtl/alu32_addsub.sv
module alu32_addsub #(
   parameter int WIDTH = 32
) (
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   input  logic             sub_i,
   output logic [WIDTH-1:0] sum_o,
   output logic             equal_o,
   output logic             less_o
);
   localparam int MSB = WIDTH - 1;

   logic [WIDTH-1:0] b_eff;
   logic             ovf;

   // Subtraction is A + ~B + 1; the carry out is simply not kept.
   assign b_eff = sub_i ? ~b_i : b_i;
   assign sum_o = a_i + b_eff + {{(WIDTH-1){1'b0}}, sub_i};

   // Signed overflow: both addends share a sign that the sum does not.
   assign ovf     = (a_i[MSB] == b_eff[MSB]) && (sum_o[MSB] != a_i[MSB]);
   assign less_o  = sum_o[MSB] ^ ovf;
   assign equal_o = ~|sum_o;
endmodule

// File: rtl/alu32_bitwise.sv
module alu32_bitwise
   import alu32_pkg::*;
#(
   parameter int WIDTH = 32
) (
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   input  bw_sel_e          sel_i,
   output logic [WIDTH-1:0] y_o
);
   always_comb begin
      unique case (sel_i)
         BW_AND:  y_o = a_i & b_i;
         BW_OR:   y_o = a_i | b_i;
         BW_XOR:  y_o = a_i ^ b_i;
         default: y_o = ~(a_i ^ b_i);
      endcase
   end
endmodule

// File: rtl/alu32_shift.sv
module alu32_shift #(
   parameter int WIDTH   = 32,
   parameter bit STAGED  = 1'b1,
   localparam int SHW    = $clog2(WIDTH)
) (
   input  logic [WIDTH-1:0] val_i,
   input  logic [SHW-1:0]   amt_i,
   input  logic             right_i,
   input  logic             arith_i,
   output logic [WIDTH-1:0] y_o
);
   generate
      if (STAGED) begin : g_staged
         logic [WIDTH-1:0] rev_in;
         logic [WIDTH-1:0] rev_out;
         logic [WIDTH-1:0] src;
         logic [WIDTH-1:0] stage [SHW+1];
         logic             fill;

         // Left shifts run through the right-shift network on a reversed word.
         for (genvar k = 0; k < WIDTH; k++) begin : g_rev
            assign rev_in[k]  = val_i[WIDTH-1-k];
            assign rev_out[k] = stage[SHW][WIDTH-1-k];
         end

         assign src      = right_i ? val_i : rev_in;
         assign fill     = right_i & arith_i & val_i[WIDTH-1];
         assign stage[0] = src;

         for (genvar s = 0; s < SHW; s++) begin : g_stage
            localparam int HOP = 1 << s;
            assign stage[s+1] = amt_i[s]
                              ? {{HOP{fill}}, stage[s][WIDTH-1:HOP]}
                              : stage[s];
         end

         assign y_o = right_i ? stage[SHW] : rev_out;
      end else begin : g_operator
         always_comb begin
            if (!right_i)
               y_o = val_i << amt_i;
            else if (arith_i)
               y_o = $unsigned($signed(val_i) >>> amt_i);
            else
               y_o = val_i >> amt_i;
         end
      end
   endgenerate
endmodule

// File: rtl/alu32_core.sv
module alu32_core
   import alu32_pkg::*;
#(
   parameter int WIDTH        = 32,
   parameter bit SHIFT_STAGED = 1'b1
) (
   input  logic [3:0]       op_i,
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   output logic [WIDTH-1:0] result_o,
   output logic             zero_o
);
   localparam int SHW = $clog2(WIDTH);

   generate
      if (WIDTH < 8) begin : g_bad_small
         $error("alu32_core: WIDTH must be at least 8");
      end
      if ((WIDTH & (WIDTH - 1)) != 0) begin : g_bad_pow2
         $error("alu32_core: WIDTH must be a power of two");
      end
   endgenerate

   alu_op_e          op;
   logic [WIDTH-1:0] sum;
   logic             eq;
   logic             lt;
   logic [WIDTH-1:0] bw_y;
   logic [WIDTH-1:0] sh_y;
   bw_sel_e          bw_sel;

   assign op = alu_op_e'(op_i);

   alu32_addsub #(.WIDTH(WIDTH)) u_addsub (
      .a_i     (a_i),
      .b_i     (b_i),
      .sub_i   (op != OP_ADD),
      .sum_o   (sum),
      .equal_o (eq),
      .less_o  (lt)
   );

   always_comb begin
      unique case (op)
         OP_AND:  bw_sel = BW_AND;
         OP_OR:   bw_sel = BW_OR;
         OP_XOR:  bw_sel = BW_XOR;
         default: bw_sel = BW_XNOR;
      endcase
   end

   alu32_bitwise #(.WIDTH(WIDTH)) u_bitwise (
      .a_i   (a_i),
      .b_i   (b_i),
      .sel_i (bw_sel),
      .y_o   (bw_y)
   );

   alu32_shift #(.WIDTH(WIDTH), .STAGED(SHIFT_STAGED)) u_shift (
      .val_i   (a_i),
      .amt_i   (b_i[SHW-1:0]),
      .right_i (op != OP_SHL),
      .arith_i (op == OP_SRA),
      .y_o     (sh_y)
   );

   always_comb begin
      result_o = '0;
      case (op)
         OP_ADD, OP_SUB:                  result_o = sum;
         OP_CEQ:                          result_o[0] = eq;
         OP_CLT:                          result_o[0] = lt;
         OP_CLE:                          result_o[0] = lt | eq;
         OP_AND, OP_OR, OP_XOR, OP_XNOR:  result_o = bw_y;
         OP_SHL, OP_SHR, OP_SRA:          result_o = sh_y;
         default:                         result_o = '0;
      endcase
   end

   assign zero_o = ~|result_o;
endmodule

// File: rtl/alu32_core_chk.sv
module alu32_core_chk #(
   parameter int WIDTH = 32
) (
   input logic [3:0]       op_i,
   input logic [WIDTH-1:0] a_i,
   input logic [WIDTH-1:0] b_i,
   input logic [WIDTH-1:0] result_o,
   input logic             zero_o
);
   localparam int SHW = $clog2(WIDTH);

   always_comb begin
      // R3: equality yields a pure boolean word
      if (op_i == 4'd2)
         p_eq_bool_r3: assert (result_o[WIDTH-1:1] == '0)
            else $error("p_eq_bool_r3");
      // R4: no value is less than itself
      if (op_i == 4'd3 && a_i == b_i)
         p_lt_irrefl_r4: assert (result_o == '0)
            else $error("p_lt_irrefl_r4");
      // R5: every value is less-or-equal to itself
      if (op_i == 4'd4 && a_i == b_i)
         p_le_refl_r5: assert (result_o == {{(WIDTH-1){1'b0}}, 1'b1})
            else $error("p_le_refl_r5");
      // R7: a distance whose low bits are zero leaves the operand intact
      if (op_i == 4'd9 && b_i[SHW-1:0] == '0)
         p_shl_wrap_r7: assert (result_o == a_i)
            else $error("p_shl_wrap_r7");
      // R9: the arithmetic right shift keeps the sign
      if (op_i == 4'd11)
         p_sra_sign_r9: assert (result_o[WIDTH-1] == a_i[WIDTH-1])
            else $error("p_sra_sign_r9");
      // R10: subtracting equal operands raises the zero flag
      if (op_i == 4'd1 && a_i == b_i)
         p_sub_self_zero_r10: assert (zero_o)
            else $error("p_sub_self_zero_r10");
      // R11: undefined codes produce zero with the flag set
      if (op_i >= 4'd12)
         p_undef_zero_r11: assert (zero_o && result_o == '0)
            else $error("p_undef_zero_r11");
   end
endmodule

bind alu32_core alu32_core_chk #(.WIDTH(WIDTH)) u_chk (
   .op_i     (op_i),
   .a_i      (a_i),
   .b_i      (b_i),
   .result_o (result_o),
   .zero_o   (zero_o)
);

// File: tb/alu32_core_test.sv
module alu32_core_test;
   localparam int CLK_PERIOD = 10;
   localparam int W          = 32;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic [3:0]    op_r = 4'd0;
   logic [W-1:0]  a_r  = '0;
   logic [W-1:0]  b_r  = '0;
   logic [W-1:0]  res_s, res_o;
   logic          z_s, z_o;
   int            n_checks = 0;
   int            n_fails  = 0;
   bit            done     = 1'b0;
   logic [31:0]   seed     = 32'h1234_5678;

   always #(CLK_PERIOD/2) clk = ~clk;

   alu32_core #(.WIDTH(W), .SHIFT_STAGED(1'b1)) uut (
      .op_i(op_r), .a_i(a_r), .b_i(b_r), .result_o(res_s), .zero_o(z_s));

   alu32_core #(.WIDTH(W), .SHIFT_STAGED(1'b0)) uut_alt (
      .op_i(op_r), .a_i(a_r), .b_i(b_r), .result_o(res_o), .zero_o(z_o));

   function automatic logic [W-1:0] model(input logic [3:0] op,
                                          input logic [W-1:0] a,
                                          input logic [W-1:0] b);
      int sa, sb;
      sa = $signed(a);
      sb = $signed(b);
      case (op)
         4'd0:    return a + b;
         4'd1:    return a - b;
         4'd2:    return (a == b) ? 1 : 0;
         4'd3:    return (sa < sb) ? 1 : 0;
         4'd4:    return (sa <= sb) ? 1 : 0;
         4'd5:    return a & b;
         4'd6:    return a | b;
         4'd7:    return a ^ b;
         4'd8:    return ~(a ^ b);
         4'd9:    return a << b[4:0];
         4'd10:   return a >> b[4:0];
         4'd11:   return $unsigned(sa >>> b[4:0]);
         default: return '0;
      endcase
   endfunction

   function automatic string tag_of(input logic [3:0] op);
      case (op)
         4'd0: return "R1";
         4'd1: return "R2";
         4'd2: return "R3";
         4'd3: return "R4";
         4'd4: return "R5";
         4'd5, 4'd6, 4'd7, 4'd8: return "R6";
         4'd9: return "R7";
         4'd10: return "R8";
         4'd11: return "R9";
         default: return "R11";
      endcase
   endfunction

   task automatic compare(input string tag, input string who,
                          input logic [W-1:0] got, input logic gz,
                          input logic [W-1:0] exp);
      n_checks++;
      if (got !== exp) begin
         n_fails++;
         $display("FAIL %s %s op=%0d a=%h b=%h result actual=%h expected=%h",
                  tag, who, op_r, a_r, b_r, got, exp);
      end
      n_checks++;
      if (gz !== (exp == '0)) begin
         n_fails++;
         $display("FAIL R10 %s op=%0d zero actual=%b expected=%b",
                  who, op_r, gz, (exp == '0));
      end
   endtask

   task automatic run(input logic [3:0] op, input logic [W-1:0] a,
                      input logic [W-1:0] b, input string tag);
      logic [W-1:0] exp;
      @(negedge clk);
      op_r = op; a_r = a; b_r = b;
      @(posedge clk);
      #1;
      exp = model(op, a, b);
      compare(tag, "staged", res_s, z_s, exp);
      compare(tag, "operator", res_o, z_o, exp);
   endtask

   function automatic logic [31:0] nxt(input logic [31:0] s);
      return s * 32'd1664525 + 32'd1013904223;
   endfunction

   initial begin
      repeat (3) @(posedge clk);
      rst = 1'b0;
      // quiescent state: add of zeros gives zero with flag (R1, R10)
      run(4'd0, 32'h0, 32'h0, "R10");
      run(4'd0, 32'hAAAAAAAA, 32'hAAAAAAAA, "R1");
      run(4'd0, 32'hAAAAAAAA, 32'h55555555, "R1");
      run(4'd1, 32'h1, 32'h1, "R2");
      run(4'd1, 32'h0, 32'h1, "R2");
      run(4'd2, 32'hFFFFFFFF, 32'hFFFFFFFF, "R3");
      run(4'd2, 32'h0, 32'hFFFFFFFF, "R3");
      run(4'd3, 32'h80000000, 32'h7FFFFFFF, "R4");
      run(4'd3, 32'h7FFFFFFF, 32'h80000000, "R4");
      run(4'd3, 32'h0, 32'h1, "R4");
      run(4'd3, 32'h0, 32'hFFFFFFFF, "R4");
      run(4'd4, 32'h80000000, 32'h7FFFFFFF, "R5");
      run(4'd4, 32'h7FFFFFFF, 32'h80000000, "R5");
      run(4'd4, 32'h0, 32'hFFFFFFFF, "R5");
      run(4'd4, 32'h5, 32'h5, "R5");
      run(4'd5, 32'h0F0F, 32'h7F00, "R6");
      run(4'd6, 32'h0F0F, 32'h7F00, "R6");
      run(4'd7, 32'h0F0F, 32'h7F00, "R6");
      run(4'd8, 32'h0F0F, 32'h7F00, "R6");
      run(4'd9, 32'h1, 32'd32, "R7");
      run(4'd9, 32'h1, 32'd31, "R7");
      run(4'd9, 32'h3, 32'd3, "R7");
      run(4'd10, 32'h80000000, 32'd17, "R8");
      run(4'd10, 32'hFFFFFFFF, 32'd48, "R8");
      run(4'd11, 32'h80000000, 32'd17, "R9");
      run(4'd11, 32'h40000000, 32'd30, "R9");
      run(4'd11, 32'hFFFFFFFF, 32'd31, "R9");
      for (int op = 12; op < 16; op++)
         run(op[3:0], 32'hDEADBEEF, 32'h12345678, "R11");
      for (int i = 0; i < 3000; i++) begin
         logic [3:0]  op;
         logic [31:0] a, b;
         seed = nxt(seed); op = seed[19:16];
         seed = nxt(seed); a  = seed;
         seed = nxt(seed); b  = seed;
         if (i % 5 == 0) b = a;
         if (i % 7 == 0) a = {seed[31], 31'h0};
         run(op, a, b, tag_of(op));
      end
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures",
               n_checks, n_fails);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         n_fails++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures",
                  n_checks, n_fails);
         $finish;
      end
   end
endmodule